// File: doc/BRIEF.md
# Binary Tap Timer with Maskable Interrupt Flags

This block is a free-running 7-bit binary counter clocked in the system clock domain. It advances by one for each single-cycle 256 Hz enable pulse. Counter bit 0 toggles at 128 Hz, so the upper bits act as a ladder of slower frequency taps. Software reads the four most significant bits as a nibble holding the 16 Hz, 8 Hz, 4 Hz and 2 Hz taps. A synchronous timer-clear input restarts the count from zero.

Three taps produce events when they fall from 1 to 0: 32 Hz, 8 Hz and 2 Hz. Each event latches a status flag, whatever the mask says. A mask register enables each flag separately onto one interrupt request line. Reading the flag register returns the flags and clears them in the same access. An event that arrives during that read is not lost.

Top module: `tap_timer`

## Requirements
- R1: After reset the counter, the flags, the mask and `irq` are all 0, and reads of every address return 0.
- R2: Each cycle with `tick_en` high and `timer_clr` low adds one to the counter, and the count wraps from 127 to 0. Without a tick the count holds.
- R3: A read at address 0 returns counter bits 6..3 (bit 0 = 16 Hz, bit 1 = 8 Hz, bit 2 = 4 Hz, bit 3 = 2 Hz). A read at address 3 returns 0. Read data appears on `reg_rdata` one cycle after `reg_rd` and holds until the next read.
- R4: A tick that carries counter bit 2 from 1 to 0 sets flag bit 0 (32 Hz). A tick that carries bit 4 from 1 to 0 sets flag bit 1 (8 Hz). A tick that carries bit 6 from 1 to 0 sets flag bit 2 (2 Hz). Address 1 returns the flags in bits 2..0.
- R5: A flag is set on its event even while its mask bit is 0. A masked flag does not raise `irq`.
- R6: A read at address 1 clears all flags at the read edge. A flag whose event falls in that same cycle stays set.
- R7: `irq` is registered. It is high in the cycle after any flag bit and its mask bit (same position, address 2) are both 1.
- R8: `timer_clr` zeroes the counter and takes priority over a tick. It produces no flag event and leaves the mask and the flags unchanged.
- R9: Writing address 2 loads the mask from `reg_wdata[2:0]`, and reading it back returns it. Writes to addresses 0, 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle 256 Hz advance pulse |
| timer_clr | input | 1 | Synchronous counter clear |
| reg_addr | input | 2 | Register select: 0 count, 1 flags, 2 mask |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 3 | Write data for the mask |
| reg_rdata | output | 4 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag read that falls in the same cycle as a tap's falling edge. The bench first brings the count to 15, where the next tick carries bit 2 to zero, and clears the flags by reading them. It then raises `tick_en` and a flag read on the same edge. The read must return the old empty flags, and a second read must still find the 32 Hz flag set. In the same way, a clear combined with a tick at a count ending in 7 confirms that no spurious event appears.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  localparam int CNT_W   = 7;
  localparam int NIB_W   = 4;
  localparam int NUM_EVT = 3;

  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_FLG = 2'd1;
  localparam logic [1:0] ADDR_MSK = 2'd2;

  // counter bit whose falling edge raises event k (32 Hz, 8 Hz, 2 Hz)
  function automatic int tap_bit(input int k);
    return 2 + 2 * k;
  endfunction
endpackage

// File: rtl/tap_timer_cnt.sv
module tap_timer_cnt
  import tap_timer_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int NEVT = NUM_EVT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            timer_clr,
  output logic [W-1:0]    cnt,
  output logic [NEVT-1:0] fall
);

  always_ff @(posedge clk) begin
    if (rst || timer_clr) cnt <= '0;
    else if (tick_en)     cnt <= cnt + W'(1);
  end

  // a tap falls when every bit at and below it is 1 and the count advances
  for (genvar k = 0; k < NEVT; k++) begin : g_fall
    localparam int TB = tap_bit(k);
    assign fall[k] = tick_en & ~timer_clr & (&cnt[TB:0]);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !timer_clr) |=> $stable(cnt));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !timer_clr && (&cnt)) |=> (cnt == '0));
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    timer_clr |=> (cnt == '0));

endmodule

// File: rtl/tap_timer_flags.sv
module tap_timer_flags #(
  parameter int NEVT = tap_timer_pkg::NUM_EVT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic            rd_clr,
  output logic [NEVT-1:0] flags
);

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~{NEVT{rd_clr}}) | evt;
  end

  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ((flags & ~$past(evt)) == '0));

endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               timer_clr,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [NUM_EVT-1:0] reg_wdata,
  output logic [NIB_W-1:0]   reg_rdata,
  output logic               irq
);

  localparam int PAD_W = NIB_W - NUM_EVT;

  logic [CNT_W-1:0]   cnt;
  logic [NUM_EVT-1:0] fall;
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] mask;
  logic               rd_flg;
  logic               wr_msk;

  assign rd_flg = reg_rd && (reg_addr == ADDR_FLG);
  assign wr_msk = reg_wr && (reg_addr == ADDR_MSK);

  tap_timer_cnt #(.W(CNT_W), .NEVT(NUM_EVT)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .timer_clr(timer_clr),
    .cnt      (cnt),
    .fall     (fall)
  );

  tap_timer_flags #(.NEVT(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .evt   (fall),
    .rd_clr(rd_flg),
    .flags (flags)
  );

  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (wr_msk) mask <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_CNT: reg_rdata <= cnt[CNT_W-1 -: NIB_W];
        ADDR_FLG: reg_rdata <= {{PAD_W{1'b0}}, flags};
        ADDR_MSK: reg_rdata <= {{PAD_W{1'b0}}, mask};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & mask);
  end

  p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(mask) != '0));
  p_mask_kept_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_msk |=> $stable(mask));
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/tap_timer_bench.sv
module tap_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       timer_clr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_wdata = 3'd0;
  logic [3:0] reg_rdata;
  logic       irq;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  logic  rd_seen = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  tap_timer u_tap_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .timer_clr(timer_clr),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: compare read data with the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL unexpected read: got %0h, expected none", reg_rdata);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_errors++;
          $display("FAIL %s: rdata=%0h expected=%0h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a;
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_checks++;
    if (irq !== e) begin
      n_errors++;
      $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(2'd0, 4'h0, "R1 count after reset");
    rd(2'd1, 4'h0, "R1 flags after reset");
    rd(2'd2, 4'h0, "R1 mask after reset");
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd3, 4'h0, "R3 reserved address");
    // 8 ticks: 7->8 drops bit 2
    tick(8);
    rd(2'd0, 4'h1, "R3 nibble at count 8");
    chk_irq(1'b0, "R5 masked flag no irq");
    rd(2'd1, 4'h1, "R5 flag set while masked");
    rd(2'd1, 4'h0, "R6 flags cleared by read");
    idle(5);
    rd(2'd0, 4'h1, "R2 count holds without tick");
    wr(2'd2, 3'd7);
    rd(2'd2, 4'h7, "R9 mask readback");
    tick(8);
    idle(1);
    chk_irq(1'b1, "R7 irq on enabled flag");
    rd(2'd1, 4'h1, "R4 32Hz flag at 15->16");
    chk_irq(1'b0, "R7 irq drops after clear");
    tick(16);
    rd(2'd1, 4'h3, "R4 32Hz and 8Hz at 31->32");
    rd(2'd0, 4'h4, "R3 nibble at count 32");
    tick(96);
    rd(2'd0, 4'h0, "R2 wrap 127->0");
    rd(2'd1, 4'h7, "R4 all taps at wrap");
    // per-bit masking
    wr(2'd2, 3'd4);
    tick(8);
    idle(1);
    chk_irq(1'b0, "R7 other mask bit only");
    wr(2'd2, 3'd1);
    idle(1);
    chk_irq(1'b1, "R7 matching mask bit");
    rd(2'd1, 4'h1, "R6 clear before coincidence");
    // coincident event and read: count 8 -> 15
    tick(7);
    exp_q.push_back(4'h0);
    tag_q.push_back("R6 read during event returns old");
    reg_addr = 2'd1;
    reg_rd = 1'b1;
    tick_en = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    tick_en = 1'b0;
    @(negedge clk);
    rd(2'd1, 4'h1, "R6 coincident event kept");
    // timer clear: count 16 -> 23 then clear with tick
    wr(2'd2, 3'd5);
    tick(7);
    timer_clr = 1'b1;
    tick_en = 1'b1;
    @(negedge clk);
    timer_clr = 1'b0;
    tick_en = 1'b0;
    rd(2'd0, 4'h0, "R8 clear beats tick");
    rd(2'd1, 4'h0, "R8 clear makes no event");
    rd(2'd2, 4'h5, "R8 mask kept across clear");
    tick(9);
    timer_clr = 1'b1;
    @(negedge clk);
    timer_clr = 1'b0;
    rd(2'd1, 4'h1, "R8 flags kept across clear");
    tick(9);
    // ignored writes
    wr(2'd1, 3'd7);
    rd(2'd1, 4'h1, "R9 flag write ignored");
    wr(2'd0, 3'd7);
    wr(2'd3, 3'd7);
    rd(2'd0, 4'h1, "R9 count write ignored");
    rd(2'd2, 4'h5, "R9 mask unchanged by other writes");
    idle(3);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule